// File: doc/BRIEF.md
# DMA Descriptor List Sequencer

This block is the control sequencer of a single DMA channel. It holds a 64-bit pointer to the current descriptor, written by software as two 32-bit halves, together with a run flag, an error flag and two trigger-disable bits. Once processing starts, the block walks a linked list of descriptors in memory. For each one it reads the descriptor, hands it to an external execution unit, writes the completion status back into the descriptor, and then follows the next pointer or stops.

Processing starts in one of two ways. Software can set the run bit, or software can write a non-zero value to either pointer half, and each of the two pointer triggers can be switched off on its own. Memory is reached through an abstract request/response port. A request stays valid until it is accepted, and exactly one response follows each accepted request. The status write-back touches a single byte, which is the most significant byte of the descriptor's first 32-bit word.

Top module: `dlist_seq`

## Requirements
- R1: No start trigger has any effect while the error flag `err_o` is set.
- R2: With the channel idle, a control write (`reg_sel`=2) with bit 0 set starts processing.
- R3: With the channel idle, a non-zero write to the low pointer half (`reg_sel`=0) starts processing unless configuration bit 0 (`reg_sel`=3) is set.
- R4: With the channel idle, a non-zero write to the high pointer half (`reg_sel`=1) starts processing unless configuration bit 1 is set. A write of zero to either half never starts processing.
- R5: In the cycle after a start, the block requests a read at {high half, low half} with all four byte enables set.
- R6: A start sets `run_o` and clears `idle_o`. A halt clears `run_o` and sets `idle_o`. The two flags are always complementary.
- R7: Each descriptor is handled in a fixed order. First comes the read response. Then `exec_valid_o` presents the descriptor until `exec_done`. Only after that does the block issue the write-back.
- R8: The write-back goes to the current descriptor address with byte enables 4'b1000, and the execution status sits in write data bits [31:24].
- R9: The descriptor uses bits [127:64] as the next pointer and bit 0 as the last flag. If the next pointer is non-zero and the last flag is clear, the block loads the next pointer and reads that descriptor. Otherwise it halts, and the pointer keeps the address of the final descriptor.
- R10: An error response to a read or a write sets `err_o` and halts the channel. A control write with bit 1 set clears `err_o`.
- R11: While the channel is busy, pointer writes and start triggers are ignored, and `cur_ptr_o` changes only when a chained pointer is loaded.
- R12: A request that is not accepted stays valid, with its address unchanged, in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 pointer low, 1 pointer high, 2 control, 3 configuration |
| reg_wdata | input | 32 | Register write data |
| run_o | output | 1 | Channel running |
| idle_o | output | 1 | Channel idle |
| err_o | output | 1 | Channel error flag |
| cur_ptr_o | output | 64 | Current descriptor pointer |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 for write-back, 0 for descriptor read |
| mem_req_addr | output | 64 | Request address |
| mem_req_be | output | 4 | Write byte enables |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Response valid |
| mem_rsp_err | input | 1 | Response carries an error |
| mem_rsp_data | input | 128 | Descriptor read data |
| exec_valid_o | output | 1 | Descriptor handed to the execution unit |
| exec_desc_o | output | 128 | Descriptor contents |
| exec_done | input | 1 | Execution finished |
| exec_status | input | 8 | Completion status |

## Verification
A register write that triggers a start appears one cycle later. At that point `run_o` is high, `idle_o` is low and the read request for the pointer is valid. A response or an `exec_done` takes effect at the clock edge that samples it: a halt, an error flag or a chained pointer is visible right after that edge, and the next request (a chained read or the write-back) is valid in that same cycle. The bench drives every input at the falling edge and samples outputs at the following falling edge, so each compare sees exactly one rising edge's worth of change. Its reference model advances by the same single edge before each comparison.

// File: rtl/dlist_pkg.sv
package dlist_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_EXEC,
    ST_WB_REQ,
    ST_WB_WAIT
  } seq_state_e;

  // Register select codes; pointer halves use codes 0/1 to match the
  // configuration bit that masks their trigger.
  localparam logic [1:0] SEL_PTR_LO = 2'd0;
  localparam logic [1:0] SEL_PTR_HI = 2'd1;
  localparam logic [1:0] SEL_CTL    = 2'd2;
  localparam logic [1:0] SEL_CFG    = 2'd3;

  localparam int CTL_RUN_BIT     = 0;
  localparam int CTL_CLR_ERR_BIT = 1;
  localparam int DESC_LAST_BIT   = 0;
  localparam int N_HALVES        = 2;

endpackage

// File: rtl/dlist_trig.sv
module dlist_trig
  import dlist_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic              idle,
  input  logic              err,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [HALF_W-1:0] reg_wdata,
  input  logic [1:0]        cfg_off,
  output logic              start
);

  logic [N_HALVES-1:0] half_hit;
  logic                run_hit;
  logic                nz;

  assign nz = |reg_wdata;

  for (genvar h = 0; h < N_HALVES; h++) begin : g_half
    assign half_hit[h] = (reg_sel == 2'(h)) && nz && !cfg_off[h];
  end

  assign run_hit = (reg_sel == SEL_CTL) && reg_wdata[CTL_RUN_BIT];
  assign start   = reg_we && idle && !err && ((|half_hit) || run_hit);

endmodule

// File: rtl/dlist_csr.sv
module dlist_csr
  import dlist_pkg::*;
#(
  parameter int ADDR_W = 64,
  localparam int HALF_W = ADDR_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [HALF_W-1:0] reg_wdata,
  input  logic              idle,
  input  logic              start,
  input  logic              halt,
  input  logic              halt_err,
  input  logic              ld_next,
  input  logic [ADDR_W-1:0] next_ptr,
  output logic [ADDR_W-1:0] ptr,
  output logic [1:0]        cfg_off,
  output logic              run,
  output logic              err
);

  logic [ADDR_W-1:0]   ptr_q, ptr_d;
  logic [N_HALVES-1:0] wr_half;
  logic                ptr_en;
  logic [1:0]          cfg_q, cfg_d;
  logic                cfg_en;
  logic                run_q, run_d;
  logic                err_q, err_d;
  logic                clr_err;

  for (genvar h = 0; h < N_HALVES; h++) begin : g_ptr
    assign wr_half[h] = reg_we && idle && (reg_sel == 2'(h));
    assign ptr_d[h*HALF_W +: HALF_W] = ld_next    ? next_ptr[h*HALF_W +: HALF_W] :
                                       wr_half[h] ? reg_wdata :
                                                    ptr_q[h*HALF_W +: HALF_W];
  end

  assign ptr_en  = ld_next || (|wr_half);
  assign cfg_en  = reg_we && (reg_sel == SEL_CFG);
  assign cfg_d   = reg_wdata[1:0];
  assign clr_err = reg_we && (reg_sel == SEL_CTL) && reg_wdata[CTL_CLR_ERR_BIT];

  always_comb begin
    run_d = run_q;
    if (start)     run_d = 1'b1;
    else if (halt) run_d = 1'b0;
    err_d = err_q;
    if (halt_err)     err_d = 1'b1;
    else if (clr_err) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cfg_q <= '0;
      run_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (ptr_en) ptr_q <= ptr_d;
      if (cfg_en) cfg_q <= cfg_d;
      run_q <= run_d;
      err_q <= err_d;
    end
  end

  assign ptr     = ptr_q;
  assign cfg_off = cfg_q;
  assign run     = run_q;
  assign err     = err_q;

endmodule

// File: rtl/dlist_fsm.sv
module dlist_fsm
  import dlist_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DESC_W = 128,
  parameter int DATA_W = 32,
  parameter int STAT_W = 8,
  localparam int BE_W      = DATA_W / 8,
  localparam int STAT_BYTE = BE_W - 1,
  localparam int NEXT_LSB  = DESC_W - ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] ptr,
  output logic              idle,
  output logic              halt,
  output logic              halt_err,
  output logic              ld_next,
  output logic [ADDR_W-1:0] next_ptr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [BE_W-1:0]   mem_req_be,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_err,
  input  logic [DESC_W-1:0] mem_rsp_data,
  output logic              exec_valid,
  output logic [DESC_W-1:0] exec_desc,
  input  logic              exec_done,
  input  logic [STAT_W-1:0] exec_status
);

  seq_state_e        state_q, state_d;
  logic [DESC_W-1:0] desc_q;
  logic              desc_en;
  logic [STAT_W-1:0] stat_q;
  logic              stat_en;
  logic              end_of_list;
  logic              rsp_ok, rsp_bad;

  assign rsp_ok      = mem_rsp_valid && !mem_rsp_err;
  assign rsp_bad     = mem_rsp_valid && mem_rsp_err;
  assign next_ptr    = desc_q[NEXT_LSB +: ADDR_W];
  assign end_of_list = (next_ptr == '0) || desc_q[DESC_LAST_BIT];

  always_comb begin
    state_d  = state_q;
    halt     = 1'b0;
    halt_err = 1'b0;
    ld_next  = 1'b0;
    desc_en  = 1'b0;
    stat_en  = 1'b0;
    unique case (state_q)
      ST_IDLE:    if (start) state_d = ST_RD_REQ;
      ST_RD_REQ:  if (mem_req_ready) state_d = ST_RD_WAIT;
      ST_RD_WAIT: begin
        if (rsp_bad) begin
          halt     = 1'b1;
          halt_err = 1'b1;
          state_d  = ST_IDLE;
        end else if (rsp_ok) begin
          desc_en = 1'b1;
          state_d = ST_EXEC;
        end
      end
      ST_EXEC: begin
        if (exec_done) begin
          stat_en = 1'b1;
          state_d = ST_WB_REQ;
        end
      end
      ST_WB_REQ:  if (mem_req_ready) state_d = ST_WB_WAIT;
      ST_WB_WAIT: begin
        if (rsp_bad) begin
          halt     = 1'b1;
          halt_err = 1'b1;
          state_d  = ST_IDLE;
        end else if (rsp_ok) begin
          if (end_of_list) begin
            halt    = 1'b1;
            state_d = ST_IDLE;
          end else begin
            ld_next = 1'b1;
            state_d = ST_RD_REQ;
          end
        end
      end
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      desc_q  <= '0;
      stat_q  <= '0;
    end else begin
      state_q <= state_d;
      if (desc_en) desc_q <= mem_rsp_data;
      if (stat_en) stat_q <= exec_status;
    end
  end

  assign idle          = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_RD_REQ) || (state_q == ST_WB_REQ);
  assign mem_req_write = (state_q == ST_WB_REQ);
  assign mem_req_addr  = ptr;
  assign mem_req_be    = mem_req_write ? (BE_W'(1) << STAT_BYTE) : '1;
  assign mem_req_wdata = DATA_W'(stat_q) << (8 * STAT_BYTE);
  assign exec_valid    = (state_q == ST_EXEC);
  assign exec_desc     = desc_q;

endmodule

// File: rtl/dlist_seq.sv
module dlist_seq
  import dlist_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DESC_W = 128,
  parameter int DATA_W = 32,
  parameter int STAT_W = 8,
  localparam int HALF_W = ADDR_W / 2,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [HALF_W-1:0] reg_wdata,
  output logic              run_o,
  output logic              idle_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] cur_ptr_o,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [BE_W-1:0]   mem_req_be,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_err,
  input  logic [DESC_W-1:0] mem_rsp_data,
  output logic              exec_valid_o,
  output logic [DESC_W-1:0] exec_desc_o,
  input  logic              exec_done,
  input  logic [STAT_W-1:0] exec_status
);

  logic              idle, start, halt, halt_err, ld_next, run, err;
  logic [ADDR_W-1:0] ptr, next_ptr;
  logic [1:0]        cfg_off;

  dlist_trig #(.HALF_W(HALF_W)) u_trig (
    .idle      (idle),
    .err       (err),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .cfg_off   (cfg_off),
    .start     (start)
  );

  dlist_csr #(.ADDR_W(ADDR_W)) u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .idle      (idle),
    .start     (start),
    .halt      (halt),
    .halt_err  (halt_err),
    .ld_next   (ld_next),
    .next_ptr  (next_ptr),
    .ptr       (ptr),
    .cfg_off   (cfg_off),
    .run       (run),
    .err       (err)
  );

  dlist_fsm #(
    .ADDR_W (ADDR_W),
    .DESC_W (DESC_W),
    .DATA_W (DATA_W),
    .STAT_W (STAT_W)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .ptr           (ptr),
    .idle          (idle),
    .halt          (halt),
    .halt_err      (halt_err),
    .ld_next       (ld_next),
    .next_ptr      (next_ptr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_be    (mem_req_be),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_err   (mem_rsp_err),
    .mem_rsp_data  (mem_rsp_data),
    .exec_valid    (exec_valid_o),
    .exec_desc     (exec_desc_o),
    .exec_done     (exec_done),
    .exec_status   (exec_status)
  );

  assign run_o     = run;
  assign idle_o    = idle;
  assign err_o     = err;
  assign cur_ptr_o = ptr;

endmodule

// File: rtl/dlist_seq_chk.sv
module dlist_seq_chk #(
  parameter int ADDR_W = 64,
  parameter int BE_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_o,
  input logic              idle_o,
  input logic              err_o,
  input logic [ADDR_W-1:0] cur_ptr_o,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [BE_W-1:0]   mem_req_be,
  input logic              mem_rsp_valid,
  input logic              exec_valid_o
);

  AST_START_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_o) |-> $past(!err_o)); // R1

  AST_START_READS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_o) |-> (mem_req_valid && !mem_req_write && mem_req_be == '1)); // R5

  AST_RUN_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    run_o != idle_o); // R6

  AST_EXEC_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exec_valid_o) |-> $past(mem_rsp_valid)); // R7

  AST_WB_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> (mem_req_be == BE_W'(1) << (BE_W - 1))); // R8

  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> (idle_o && !run_o)); // R10

  AST_BUSY_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!idle_o) && !$past(mem_rsp_valid)) |-> $stable(cur_ptr_o)); // R11

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R12

endmodule

bind dlist_seq dlist_seq_chk #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .run_o         (run_o),
  .idle_o        (idle_o),
  .err_o         (err_o),
  .cur_ptr_o     (cur_ptr_o),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_be    (mem_req_be),
  .mem_rsp_valid (mem_rsp_valid),
  .exec_valid_o  (exec_valid_o)
);

// File: tb/dlist_seq_tb.sv
module dlist_seq_tb;
  localparam int CLK_PERIOD = 10;

  localparam logic [63:0] A_PTR = 64'h0000_0001_0000_0100;
  localparam logic [63:0] B_PTR = 64'h0000_0001_0000_0200;
  localparam logic [63:0] C_PTR = 64'h0000_0002_0000_0040;
  localparam logic [63:0] D_PTR = 64'h0000_0001_0000_0300;
  localparam logic [63:0] NONE  = 64'hFFFF_FFFF_FFFF_FFFF;

  logic         clk;
  logic         rst_n;
  logic         reg_we;
  logic [1:0]   reg_sel;
  logic [31:0]  reg_wdata;
  logic         run_o, idle_o, err_o;
  logic [63:0]  cur_ptr_o;
  logic         mem_req_valid, mem_req_ready, mem_req_write;
  logic [63:0]  mem_req_addr;
  logic [3:0]   mem_req_be;
  logic [31:0]  mem_req_wdata;
  logic         mem_rsp_valid, mem_rsp_err;
  logic [127:0] mem_rsp_data;
  logic         exec_valid_o;
  logic [127:0] exec_desc_o;
  logic         exec_done;
  logic [7:0]   exec_status;

  dlist_seq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .run_o(run_o), .idle_o(idle_o), .err_o(err_o), .cur_ptr_o(cur_ptr_o),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_be(mem_req_be), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err), .mem_rsp_data(mem_rsp_data),
    .exec_valid_o(exec_valid_o), .exec_desc_o(exec_desc_o), .exec_done(exec_done),
    .exec_status(exec_status)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  // reference model state
  bit          m_busy, m_err;
  logic [63:0] m_ptr;
  logic [1:0]  m_cfg;
  logic [127:0] dmem [logic [63:0]];
  logic [63:0] bad_rd, bad_wr;
  int          rsp_cd, rsp_lat, ex_cd, ex_lat;
  bit          rsp_is_wr, rdy_toggle, rdy_phase, ex_seen;
  logic [7:0]  ex_stat;
  bit          st_we;
  logic [1:0]  st_sel;
  logic [31:0] st_data;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mk(input logic [63:0] nxt, input bit last, input logic [31:0] pay);
    return {nxt, pay, 8'h00, 23'h1A2B3C, last};
  endfunction

  task automatic model_reg();
    bit go;
    go = 1'b0;
    if (st_sel == 2'd3) m_cfg = st_data[1:0];
    if (!m_busy) begin
      case (st_sel)
        2'd0: begin m_ptr[31:0]  = st_data; go = (st_data != 0) && !m_cfg[0]; end
        2'd1: begin m_ptr[63:32] = st_data; go = (st_data != 0) && !m_cfg[1]; end
        2'd2: go = st_data[0];
        default: go = 1'b0;
      endcase
      if (go && !m_err) m_busy = 1'b1;
    end
    if (st_sel == 2'd2 && st_data[1]) m_err = 1'b0;
  endtask

  task automatic tick();
    bit rdy;
    logic [127:0] d;
    @(negedge clk);
    chk(run_o === m_busy, "R6 run", 128'(run_o), 128'(m_busy));
    chk(idle_o === !m_busy, "R6 idle", 128'(idle_o), 128'(!m_busy));
    chk(err_o === m_err, "R10 err", 128'(err_o), 128'(m_err));
    chk(cur_ptr_o === m_ptr, "R11 ptr", 128'(cur_ptr_o), 128'(m_ptr));
    mem_rsp_valid = 1'b0;
    mem_rsp_err   = 1'b0;
    exec_done     = 1'b0;
    reg_we        = 1'b0;
    if (st_we) begin
      reg_we = 1'b1; reg_sel = st_sel; reg_wdata = st_data;
      model_reg();
      st_we = 1'b0;
    end
    if (exec_valid_o) begin
      if (ex_cd < 0) begin
        ex_cd = ex_lat;
        chk(exec_desc_o === dmem[m_ptr], "R7 desc", exec_desc_o, dmem[m_ptr]);
      end
      if (ex_cd == 0) begin
        exec_done = 1'b1;
        ex_stat = m_ptr[7:0] ^ 8'h5A;
        exec_status = ex_stat;
        ex_seen = 1'b1;
        ex_cd = -1;
      end else ex_cd--;
    end
    if (rsp_cd == 0) begin
      mem_rsp_valid = 1'b1;
      rsp_cd = -1;
      if (!rsp_is_wr) begin
        mem_rsp_data = dmem.exists(m_ptr) ? dmem[m_ptr] : '0;
        if (m_ptr == bad_rd) begin mem_rsp_err = 1'b1; m_busy = 0; m_err = 1; end
      end else if (m_ptr == bad_wr) begin
        mem_rsp_err = 1'b1; m_busy = 0; m_err = 1;
      end else begin
        d = dmem[m_ptr];
        if (d[127:64] != 0 && !d[0]) m_ptr = d[127:64];
        else m_busy = 0;
      end
    end else if (rsp_cd > 0) rsp_cd--;
    rdy = rdy_toggle ? rdy_phase : 1'b1;
    rdy_phase = !rdy_phase;
    mem_req_ready = rdy;
    if (mem_req_valid && rdy) begin
      rsp_cd = rsp_lat;
      rsp_is_wr = mem_req_write;
      chk(mem_req_addr === m_ptr, "R8 req addr", 128'(mem_req_addr), 128'(m_ptr));
      if (mem_req_write) begin
        chk(mem_req_be === 4'b1000, "R8 be", 128'(mem_req_be), 128'(4'b1000));
        chk(mem_req_wdata[31:24] === ex_stat, "R8 status", 128'(mem_req_wdata[31:24]), 128'(ex_stat));
        chk(ex_seen, "R7 order", 128'(ex_seen), 128'(1));
      end else begin
        chk(mem_req_be === 4'hF, "R5 be", 128'(mem_req_be), 128'(4'hF));
        ex_seen = 1'b0;
      end
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    st_we = 1'b1; st_sel = sel; st_data = data;
    tick();
  endtask

  task automatic probe(input string req, input bit exp_busy, input logic [63:0] exp_addr);
    tick();
    chk(!idle_o === exp_busy, req, 128'(!idle_o), 128'(exp_busy));
    if (exp_busy)
      chk(mem_req_valid && !mem_req_write && mem_req_addr === exp_addr, "R5 first read",
          128'(mem_req_addr), 128'(exp_addr));
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && m_busy; i++) tick();
    tick();
  endtask

  task automatic set_ptr(input logic [63:0] p);
    wr(2'd3, 32'h3); wr(2'd0, p[31:0]); wr(2'd1, p[63:32]); wr(2'd3, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    m_busy = 0; m_err = 0; m_ptr = '0; m_cfg = '0;
    bad_rd = NONE; bad_wr = NONE;
    rsp_cd = -1; rsp_lat = 0; ex_cd = -1; ex_lat = 1;
    rsp_is_wr = 0; rdy_toggle = 0; rdy_phase = 0; ex_seen = 0; ex_stat = '0;
    st_we = 0; st_sel = '0; st_data = '0;
    reg_we = 0; reg_sel = '0; reg_wdata = '0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_err = 0; mem_rsp_data = '0;
    exec_done = 0; exec_status = '0;
    dmem[A_PTR] = mk(B_PTR, 1'b0, 32'hAAAA_0001);
    dmem[B_PTR] = mk(C_PTR, 1'b0, 32'hBBBB_0002);
    dmem[C_PTR] = mk(64'h0, 1'b0, 32'hCCCC_0003);
    dmem[D_PTR] = mk(A_PTR, 1'b1, 32'hDDDD_0004);
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    chk(idle_o === 1'b1 && run_o === 1'b0 && err_o === 1'b0, "R6 reset", 128'(idle_o), 128'(1));

    // masked high trigger, then low trigger walks A->B->C
    wr(2'd3, 32'h2);
    wr(2'd1, 32'h1);
    probe("R4 high masked", 1'b0, 64'h0);
    wr(2'd0, 32'h100);
    probe("R3 low start", 1'b1, A_PTR);
    wait_idle();
    chk(cur_ptr_o === C_PTR, "R9 chain end", 128'(cur_ptr_o), 128'(C_PTR));

    // last flag stops even with non-zero next
    set_ptr(D_PTR);
    wr(2'd2, 32'h1);
    probe("R2 run start", 1'b1, D_PTR);
    wait_idle();
    chk(cur_ptr_o === D_PTR, "R9 last flag", 128'(cur_ptr_o), 128'(D_PTR));

    // zero write never starts
    wr(2'd0, 32'h0);
    probe("R4 zero write", 1'b0, 64'h0);

    // high-half trigger
    wr(2'd3, 32'h1); wr(2'd0, 32'h40); wr(2'd3, 32'h0);
    wr(2'd1, 32'h2);
    probe("R4 high start", 1'b1, C_PTR);
    wait_idle();

    // masked low trigger
    wr(2'd3, 32'h1);
    wr(2'd0, 32'h100);
    probe("R3 low masked", 1'b0, 64'h0);

    // triggers and pointer writes while busy
    set_ptr(A_PTR);
    ex_lat = 5;
    wr(2'd2, 32'h1);
    wr(2'd0, 32'h999); wr(2'd1, 32'h7); wr(2'd2, 32'h1);
    tick();
    chk(cur_ptr_o === A_PTR && !idle_o, "R11 busy ignore", 128'(cur_ptr_o), 128'(A_PTR));
    wait_idle();
    ex_lat = 1;

    // read error on B
    bad_rd = B_PTR;
    set_ptr(A_PTR);
    wr(2'd2, 32'h1);
    wait_idle();
    chk(err_o === 1'b1 && cur_ptr_o === B_PTR, "R10 read error", 128'(cur_ptr_o), 128'(B_PTR));
    wr(2'd2, 32'h1);
    probe("R1 run blocked", 1'b0, 64'h0);
    wr(2'd0, 32'h100);
    probe("R1 ptr blocked", 1'b0, 64'h0);
    wr(2'd2, 32'h2);
    tick();
    chk(err_o === 1'b0, "R10 clear", 128'(err_o), 128'(0));
    bad_rd = NONE;
    wr(2'd2, 32'h1);
    wait_idle();
    chk(cur_ptr_o === C_PTR, "R9 after clear", 128'(cur_ptr_o), 128'(C_PTR));

    // write-back error on B
    bad_wr = B_PTR;
    set_ptr(A_PTR);
    wr(2'd2, 32'h1);
    wait_idle();
    chk(err_o === 1'b1 && cur_ptr_o === B_PTR, "R10 write error", 128'(cur_ptr_o), 128'(B_PTR));
    wr(2'd2, 32'h2);
    bad_wr = NONE;

    // back-pressure and slow responses
    rdy_toggle = 1'b1; rsp_lat = 2; ex_lat = 2;
    set_ptr(A_PTR);
    wr(2'd2, 32'h1);
    wait_idle();
    chk(cur_ptr_o === C_PTR, "R12 stalled chain", 128'(cur_ptr_o), 128'(C_PTR));

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule